// File: doc/BRIEF.md
# Ping-Pong Sprite Line Buffer

This block composes sprite pixels for the next scanline while the current scanline is being displayed. It holds two line stores. Each store has 256 words, and each word holds two pixel entries. One store takes writes from the sprite engine while the other is scanned out to the pixel output. The two stores swap roles at every line-start pulse, so anything drawn during line N appears on the output during line N+1.

Sprite horizontal positions are 8-bit values on a 2-pixel grid. Position x selects word x, which holds screen pixels 2x and 2x+1. Sprite pixels are still placed at full 1-pixel resolution. A write request carries a full 32-pixel row of 4-bit pixel codes, a 2-bit colour-set selector and a horizontal mirror bit. The writer takes 16 cycles to store a row, one word per cycle, and skips transparent pixels. It also leaves any pixel that an earlier sprite has already written in the same line. The block also turns the sprite's line offset and vertical mirror bit into the row index used to fetch graphics. On each pixel enable, the reader outputs one entry and clears the slot it has just read. A fully scanned store is therefore empty when it next receives writes.

Top module: `sprite_linebuf`

## Requirements
- R1: After reset, `pix_o` is 0 and `req_ready_o` is 1. Both stores read as all-zero entries.
- R2: Rows written between two line-start pulses appear on `pix_o` only after the second pulse. Each pulse restarts the scan-out at screen pixel 0. A line with no writes scans out as all zeros.
- R3: A request at position x with mirror off places row pixel i (bits 4i+3:4i of `req_pix_i`) at screen pixel 2x+i.
- R4: A row pixel with code 0 is transparent and changes nothing in the store.
- R5: When sprites overlap, a screen pixel that already holds a non-zero code keeps its entry, so the earliest-written sprite wins.
- R6: With `req_hflip_i` = 1, row pixel 31-i goes to screen pixel 2x+i.
- R7: `row_o` equals `req_line_i` when `req_vflip_i` = 0, and 31 - `req_line_i` when it is 1.
- R8: Each entry is cleared to 0 after it has been output, so a store that has been fully scanned reads as zeros on later lines unless it is written again.
- R9: Pixels that would land beyond screen pixel 511 are dropped and do not wrap to pixel 0.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` then stays 0 for exactly 16 cycles. A line-start pulse abandons a row in progress, and `req_ready_o` is 1 on the next cycle.
- R11: On each `pix_en_i` cycle, `pix_o` is loaded as {colour set, pixel code} of the next screen pixel. When `pix_en_i` is 0, `pix_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | Line-start pulse; swaps the two stores |
| pix_en_i | input | 1 | Pixel enable for scan-out |
| req_valid_i | input | 1 | Row write request valid |
| req_ready_o | output | 1 | Writer is idle and can accept a request |
| req_x_i | input | 8 | Horizontal position on the 2-pixel grid |
| req_pix_i | input | 128 | 32 pixel codes, pixel i at bits 4i+3:4i |
| req_cset_i | input | 2 | Colour-set selector |
| req_hflip_i | input | 1 | Horizontal mirror |
| req_line_i | input | 5 | Line offset inside the sprite |
| req_vflip_i | input | 1 | Vertical mirror |
| row_o | output | 5 | Graphics row index after vertical mirror |
| pix_o | output | 6 | Scanned pixel {colour set, code} |

## Verification
A store-select bit that fails to toggle makes the line just written reappear one line late or not at all. The first scan after the faulty pulse then shows an empty line or a stale one. If the clear-on-read path is broken, a later scan of the same store shows old sprites. That shows up two line pulses after the damage. Errors in the mirror, offset or clipping arithmetic show up as misplaced entries within the single scan that follows the write. Errors in the priority check show up only in lines where sprites overlap.

// File: rtl/sprlb_pkg.sv
package sprlb_pkg;
  // two screen pixels per store word (fixed by the 2-pixel position grid)
  localparam int unsigned SLOTS = 2;

  function automatic logic [4:0] mirror_row(input logic [4:0] line, input logic flip);
    return flip ? ~line : line;
  endfunction
endpackage

// File: rtl/sprlb_bank.sv
module sprlb_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ENT_W  = 6,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned WORD_W = sprlb_pkg::SLOTS * ENT_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [sprlb_pkg::SLOTS-1:0]   we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [WORD_W-1:0]             rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int s = 0; s < sprlb_pkg::SLOTS; s++)
        if (we_i[s]) mem_q[addr_i][s*ENT_W +: ENT_W] <= wdata_i[s*ENT_W +: ENT_W];
    end
  end
endmodule

// File: rtl/sprlb_writer.sv
module sprlb_writer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PIX_W  = 4,
  parameter int unsigned CSET_W = 2,
  parameter int unsigned SPR_W  = 32,
  localparam int unsigned ENT_W  = PIX_W + CSET_W,
  localparam int unsigned WORD_W = sprlb_pkg::SLOTS * ENT_W,
  localparam int unsigned NWORDS = SPR_W / sprlb_pkg::SLOTS,
  localparam int unsigned KW     = $clog2(NWORDS),
  localparam int unsigned IW     = $clog2(SPR_W)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        abort_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           req_x_i,
  input  logic [SPR_W*PIX_W-1:0]      req_pix_i,
  input  logic [CSET_W-1:0]           req_cset_i,
  input  logic                        req_hflip_i,
  output logic [sprlb_pkg::SLOTS-1:0] we_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [WORD_W-1:0]           wdata_o,
  input  logic [WORD_W-1:0]           rdata_i
);
  localparam logic [KW-1:0] K_LAST = KW'(NWORDS - 1);

  logic                   busy_q;
  logic [KW-1:0]          k_q;
  logic [ADDR_W-1:0]      x_q;
  logic [SPR_W*PIX_W-1:0] pix_q;
  logic [CSET_W-1:0]      cset_q;
  logic                   hflip_q;
  logic [ADDR_W:0]        sum;
  logic                   clip;

  assign req_ready_o = !busy_q;
  assign sum    = {1'b0, x_q} + {{(ADDR_W+1-KW){1'b0}}, k_q};
  assign clip   = sum[ADDR_W];
  assign addr_o = sum[ADDR_W-1:0];

  for (genvar s = 0; s < sprlb_pkg::SLOTS; s++) begin : g_slot
    logic [IW-1:0]    idx, src;
    logic [PIX_W-1:0] code, held;
    assign idx  = {k_q, 1'(s)};
    assign src  = hflip_q ? ~idx : idx;
    assign code = pix_q[int'(src)*PIX_W +: PIX_W];
    assign held = rdata_i[s*ENT_W +: PIX_W];
    assign we_o[s] = busy_q && !clip && (code != '0) && (held == '0);
    assign wdata_o[s*ENT_W +: ENT_W] = {cset_q, code};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      k_q     <= '0;
      x_q     <= '0;
      pix_q   <= '0;
      cset_q  <= '0;
      hflip_q <= 1'b0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (req_valid_i) begin
        busy_q  <= 1'b1;
        k_q     <= '0;
        x_q     <= req_x_i;
        pix_q   <= req_pix_i;
        cset_q  <= req_cset_i;
        hflip_q <= req_hflip_i;
      end
    end else begin
      k_q <= k_q + 1'b1;
      if (k_q == K_LAST) busy_q <= 1'b0;
    end
  end

  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && req_valid_i && !abort_i) |=> (busy_q && k_q == '0));
  assert_finish_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && k_q == K_LAST && !abort_i) |=> !busy_q);
  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> req_ready_o);
endmodule

// File: rtl/sprlb_reader.sv
module sprlb_reader #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ENT_W  = 6,
  localparam int unsigned WORD_W = sprlb_pkg::SLOTS * ENT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        line_start_i,
  input  logic                        pix_en_i,
  input  logic [WORD_W-1:0]           rdata_i,
  output logic [sprlb_pkg::SLOTS-1:0] we_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [WORD_W-1:0]           wdata_o,
  output logic [ENT_W-1:0]            pix_o
);
  logic [ADDR_W:0]  cnt_q;
  logic [ENT_W-1:0] pix_q;
  logic             step;

  assign step    = pix_en_i && !line_start_i;
  assign addr_o  = cnt_q[ADDR_W:1];
  assign wdata_o = '0;   // clear-on-read
  assign pix_o   = pix_q;

  for (genvar s = 0; s < sprlb_pkg::SLOTS; s++) begin : g_clr
    assign we_o[s] = step && (cnt_q[0] == 1'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pix_q <= '0;
    end else if (line_start_i) begin
      cnt_q <= '0;
    end else if (pix_en_i) begin
      cnt_q <= cnt_q + 1'b1;
      pix_q <= rdata_i[int'(cnt_q[0])*ENT_W +: ENT_W];
    end
  end

  assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (cnt_q == '0));
  assert_advance_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(pix_o));
endmodule

// File: rtl/sprite_linebuf.sv
module sprite_linebuf #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PIX_W  = 4,
  parameter int unsigned CSET_W = 2,
  parameter int unsigned SPR_W  = 32,
  localparam int unsigned ENT_W  = PIX_W + CSET_W,
  localparam int unsigned WORD_W = sprlb_pkg::SLOTS * ENT_W,
  localparam int unsigned ROW_W  = $clog2(SPR_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   line_start_i,
  input  logic                   pix_en_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:0]      req_x_i,
  input  logic [SPR_W*PIX_W-1:0] req_pix_i,
  input  logic [CSET_W-1:0]      req_cset_i,
  input  logic                   req_hflip_i,
  input  logic [ROW_W-1:0]       req_line_i,
  input  logic                   req_vflip_i,
  output logic [ROW_W-1:0]       row_o,
  output logic [ENT_W-1:0]       pix_o
);
  localparam int unsigned S = sprlb_pkg::SLOTS;

  logic              sel_q;  // store being scanned out
  logic [S-1:0]      wr_we, rd_we;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_wdata, rd_wdata;
  logic [WORD_W-1:0] rdata [2];

  assign row_o = req_vflip_i ? ~req_line_i : req_line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sel_q <= 1'b0;
    else if (line_start_i) sel_q <= !sel_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic is_rd;
    assign is_rd = (sel_q == 1'(b));
    sprlb_bank #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (is_rd ? rd_we    : wr_we),
      .addr_i  (is_rd ? rd_addr  : wr_addr),
      .wdata_i (is_rd ? rd_wdata : wr_wdata),
      .rdata_o (rdata[b])
    );
  end

  sprlb_writer #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .CSET_W(CSET_W), .SPR_W(SPR_W)) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (line_start_i),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_x_i     (req_x_i),
    .req_pix_i   (req_pix_i),
    .req_cset_i  (req_cset_i),
    .req_hflip_i (req_hflip_i),
    .we_o        (wr_we),
    .addr_o      (wr_addr),
    .wdata_o     (wr_wdata),
    .rdata_i     (rdata[!sel_q])
  );

  sprlb_reader #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_reader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .pix_en_i     (pix_en_i),
    .rdata_i      (rdata[sel_q]),
    .we_o         (rd_we),
    .addr_o       (rd_addr),
    .wdata_o      (rd_wdata),
    .pix_o        (pix_o)
  );

  assert_swap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (sel_q != $past(sel_q)));
  assert_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(sel_q));
  assert_vflip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o + (req_vflip_i ? req_line_i : ROW_W'(0))) ==
      (req_vflip_i ? ROW_W'(SPR_W - 1) : req_line_i));
endmodule

// File: tb/sprite_linebuf_bench.sv
module sprite_linebuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 512;

  logic         clk = 0, rst_ni = 0;
  logic         line_start = 0, pix_en = 0, req_valid = 0;
  logic         req_ready;
  logic [7:0]   req_x = 0;
  logic [127:0] req_pix = 0;
  logic [1:0]   req_cset = 0;
  logic         req_hflip = 0, req_vflip = 0;
  logic [4:0]   req_line = 0, row;
  logic [5:0]   pix;

  int tests = 0, fails = 0;
  logic [5:0] nxt [NPIX];
  logic [5:0] cur [NPIX];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprite_linebuf u_sprite_linebuf (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start), .pix_en_i(pix_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_x_i(req_x),
    .req_pix_i(req_pix), .req_cset_i(req_cset), .req_hflip_i(req_hflip),
    .req_line_i(req_line), .req_vflip_i(req_vflip), .row_o(row), .pix_o(pix));

  // vector: {x[7:0], cset[1:0], hflip, seed[4:0]}
  localparam logic [15:0] VEC [8] = '{
    {8'd0,   2'd1, 1'b0, 5'd3},  {8'd10,  2'd2, 1'b1, 5'd5},
    {8'd128, 2'd3, 1'b0, 5'd7},  {8'd240, 2'd0, 1'b1, 5'd9},
    {8'd241, 2'd1, 1'b0, 5'd11}, {8'd250, 2'd2, 1'b1, 5'd13},
    {8'd255, 2'd3, 1'b0, 5'd17}, {8'd100, 2'd1, 1'b1, 5'd21}};

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] r;
    for (int k = 0; k < 32; k++) r[k*4 +: 4] = 4'((seed*3 + k*5 + ((k*seed) >> 2)) & 15);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_put(input int x, input logic [127:0] p, input logic [1:0] c, input bit hf);
    for (int i = 0; i < 32; i++) begin
      int sp = 2*x + i;
      logic [3:0] v = p[(hf ? 31 - i : i)*4 +: 4];
      if (sp < NPIX && v != 0 && nxt[sp][3:0] == 0) nxt[sp] = {c, v};
    end
  endtask

  task automatic send(input int x, input logic [127:0] p, input logic [1:0] c, input bit hf);
    int n = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_x = 8'(x); req_pix = p; req_cset = c; req_hflip = hf;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready && n < 100) begin n++; @(negedge clk); end
    check(n == 16, "R10 busy cycles", n, 16);
    model_put(x, p, c, hf);
  endtask

  task automatic pulse_line();
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    for (int i = 0; i < NPIX; i++) begin cur[i] = nxt[i]; nxt[i] = 0; end
  endtask

  task automatic scan(input string req, input bit cmp);
    int bad = -1;
    logic [5:0] a = 0;
    for (int i = 0; i < NPIX; i++) begin
      pix_en = 1;
      @(negedge clk);
      if (bad < 0 && pix != cur[i]) begin bad = i; a = pix; end
    end
    pix_en = 0;
    if (cmp) check(bad < 0, req, int'(a), bad < 0 ? 0 : int'(cur[bad]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPIX; i++) begin nxt[i] = 0; cur[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check(pix == 0, "R1 pix_o reset", int'(pix), 0);
    check(req_ready == 1, "R1 ready reset", int'(req_ready), 1);

    req_line = 5; req_vflip = 0; #1;
    check(row == 5, "R7 row no flip", int'(row), 5);
    req_vflip = 1; #1;
    check(row == 26, "R7 row flipped", int'(row), 26);
    req_line = 0; #1;
    check(row == 31, "R7 row flipped zero", int'(row), 31);
    req_vflip = 0;

    pulse_line();
    scan("R2 empty line after reset", 1);

    // table walk: one sprite per line, compared after the next pulse
    for (int v = 0; v < 8; v++) begin
      send(int'(VEC[v][15:8]), pattern(int'(VEC[v][4:0])), VEC[v][7:6], VEC[v][5]);
      pulse_line();
      scan("R2/R3/R4/R6/R9/R8 vector line", 1);
    end

    // clip boundary: last column at x=255 drops all but screen pixels 510,511
    send(255, {32{4'h7}}, 2'd1, 1'b0);
    pulse_line();
    check(cur[0] == 0 && cur[511] == 6'h17, "R9 model boundary", int'(cur[0]), 0);
    scan("R9 no wrap at x=255", 1);

    // overlap: earlier sprite keeps opaque pixels
    send(20, {32{4'h5}}, 2'd1, 1'b0);
    send(22, pattern(19), 2'd2, 1'b0);
    send(18, {16{8'h90}}, 2'd3, 1'b1);
    pulse_line();
    scan("R5 overlap priority", 1);

    // cleared stores read back empty on both following lines
    pulse_line();
    scan("R8 store B empty", 1);
    pulse_line();
    scan("R8 store A empty after scan", 1);

    // hold: put a known value on pix_o then idle
    send(0, {32{4'hA}}, 2'd3, 1'b0);
    pulse_line();
    pix_en = 1;
    @(negedge clk);
    pix_en = 0;
    check(pix == 6'h3A, "R11 first pixel format", int'(pix), 'h3A);
    repeat (5) @(negedge clk);
    check(pix == 6'h3A, "R11 hold without enable", int'(pix), 'h3A);
    pix_en = 1;
    @(negedge clk);
    pix_en = 0;
    check(pix == 6'h3A, "R11 second pixel", int'(pix), 'h3A);
    scan("R8 flush", 0);

    // abort mid-row
    req_valid = 1; req_x = 60; req_pix = {32{4'h3}}; req_cset = 0; req_hflip = 0;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R10 busy after accept", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    check(req_ready == 1, "R10 ready after abort", int'(req_ready), 1);
    scan("R10 flush aborted", 0);
    for (int i = 0; i < NPIX; i++) begin cur[i] = 0; nxt[i] = 0; end
    pulse_line();
    scan("R8 clean after abort", 1);
    pulse_line();
    scan("R8 aborted store cleared", 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule